// File: doc/BRIEF.md
# Recirculating Cache Request Matcher

This block is the data-plane heart of a load-balancing cache that holds no cached values of its own. It keeps a small table of fixed-length hashes for the hot keys and a buffer of read requests that are waiting for data. The data itself lives in records that circulate continuously: each hot key/value record leaves on a loopback output and returns on a loopback input. Every time a record passes, the block answers every request parked for that hash and then sends the record around again.

A read request whose hash is live in the table is parked. All other requests are passed on to a backend server chosen from the hash. Software-side logic outside the block inserts and removes hot items. A removed item stops hitting at once. Its parked requests are handed to the backend, and its record is dropped the next time it comes around. Hash collisions are not resolved here. Each response carries the record's full key so that the client can spot a mismatch.

Top module: `loop_cache_matcher`

## Requirements
- R1: The hash of a 64-bit key is the XOR of its four 16-bit words. All table and buffer matching uses only this hash, so a request key that differs from a cached key but has the same hash is answered with the cached record, and that record's full key is on rsp_key.
- R2: An insert accepted while ins_ready is high, with a hash not already in the table and a free table entry, makes the record appear on rout exactly once, two rising edges after acceptance. An insert whose hash is already present, or that finds the table full, produces no record.
- R3: A request whose hash is live in the table, arriving while a buffer slot is free, is parked and produces no forward.
- R4: A request whose hash is not live is forwarded on the next cycle on fwd_* with the unchanged key and client, and fwd_server equals hash modulo N_SRV.
- R5: When a record is being served, each parked request for its hash gets exactly one response. The response carries that request's client together with the record's key and value, and the slot is then freed, so a later pass of the same record produces no further response.
- R6: Responses for one record come one per cycle on consecutive cycles, in ascending slot order. Since slots fill from index 0 upward, this is the order in which the requests were parked.
- R7: After the last response for a record, the record is re-emitted on rout on the next cycle. A record with no parked requests is re-emitted two edges after it is accepted. rsp_valid and rout_valid are never high together.
- R8: A live hit that arrives when every buffer slot is occupied is forwarded as in R4.
- R9: A remove makes its hash stop hitting at once. Requests already parked for it are forwarded to the backend one per cycle in slot order. Its next returning record is dropped with no response and no rout. After that the entry is free, so the same key can be inserted again.
- R10: A request that parks while its own record is being served is answered in that same pass, before the record is re-emitted.
- R11: After reset all output valids are low and both ready outputs are high. rin_ready is low while a record is being served and whenever ins_valid is high, so an insert takes precedence over a returning record.
- R12: When a new request needs the forward port in the same cycle as a pending flush, the new request is forwarded first and the flush waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_key | input | KEY_W | Request key |
| req_client | input | CID_W | Requesting client ID |
| ins_valid | input | 1 | Insert a hot item |
| ins_ready | output | 1 | Block can accept an insert |
| ins_key | input | KEY_W | Key of inserted item |
| ins_value | input | VAL_W | Value of inserted item |
| rem_valid | input | 1 | Remove a hot item |
| rem_key | input | KEY_W | Key of removed item |
| rin_valid | input | 1 | Record returning on loopback |
| rin_ready | output | 1 | Block can accept a returning record |
| rin_key | input | KEY_W | Returning record key |
| rin_value | input | VAL_W | Returning record value |
| rout_valid | output | 1 | Record sent onto loopback |
| rout_key | output | KEY_W | Outgoing record key |
| rout_value | output | VAL_W | Outgoing record value |
| rsp_valid | output | 1 | Response to a client |
| rsp_client | output | CID_W | Client the response goes to |
| rsp_key | output | KEY_W | Record key carried in response |
| rsp_value | output | VAL_W | Record value carried in response |
| fwd_valid | output | 1 | Request forwarded to backend |
| fwd_server | output | SRV_W | Backend server index |
| fwd_key | output | KEY_W | Forwarded key |
| fwd_client | output | CID_W | Forwarded client ID |

## Verification
Parking a new request and releasing parked requests can fall in the same cycle for the same hash. The bench provokes this by driving a hit for a record on the cycle right after that record is accepted, when its first slot is being released. It then requires both clients to be answered in slot order before the record reappears. The forward port is contested in the same way: a miss is driven on the first cycle a flush could use the port, and the bench requires the order miss, then the flushed clients. Random rounds mix hits, misses and collision-free keys, and compare the exact response and forward sequences against lists built in the bench.

// File: rtl/lcm_pkg.sv
// Package: shared state encodings for the recirculating cache matcher.
// Assumes: nothing; types only.
package lcm_pkg;

    // Lifecycle of one lookup-table entry.
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_LIVE  = 2'd1,
        ENT_DYING = 2'd2
    } ent_st_e;

    // Orbit engine: waiting for a record, or serving one.
    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SERVE = 1'b1
    } eng_st_e;

endpackage

// File: rtl/lcm_hash.sv
// Module: lcm_hash
// Folds a KEY_W-bit key into HASH_W bits by XOR of its HASH_W-wide words.
// Assumes: KEY_W is a multiple of HASH_W. Purely combinational.
module lcm_hash #(
    parameter int KEY_W  = 64,
    parameter int HASH_W = 16
) (
    input  logic [KEY_W-1:0]  key,
    output logic [HASH_W-1:0] hash
);
    localparam int N_WORD = KEY_W / HASH_W;

    logic [N_WORD:0][HASH_W-1:0] acc;

    assign acc[0] = '0;

    // Chain of XOR stages, one per key word.
    for (genvar g = 0; g < N_WORD; g++) begin : g_fold
        assign acc[g+1] = acc[g] ^ key[g*HASH_W +: HASH_W];
    end

    assign hash = acc[N_WORD];
endmodule

// File: rtl/lcm_key_table.sv
// Module: lcm_key_table
// Holds the hashes of hot items with a free/live/dying state per entry.
// Answers three lookups per cycle (request, insert, recirculating record),
// allocates the lowest free entry on insert, retires entries on remove, and
// frees a dying entry once its record has been dropped and no parked request
// still carries its hash.
// Assumes: the caller inserts only when has_free is high and ins_taken is low.
module lcm_key_table
    import lcm_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int HASH_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [HASH_W-1:0]             req_hash,
    output logic                          req_live,
    input  logic                          ins_en,
    input  logic [HASH_W-1:0]             ins_hash,
    output logic                          ins_taken,
    output logic                          has_free,
    input  logic                          rem_en,
    input  logic [HASH_W-1:0]             rem_hash,
    input  logic [HASH_W-1:0]             rc_hash,
    output logic                          rc_live,
    output logic                          rc_dying,
    input  logic                          gone_en,
    output logic [N_ENT-1:0]              dying_vec,
    output logic [N_ENT-1:0][HASH_W-1:0]  dying_hash,
    input  logic [N_ENT-1:0]              ent_pend
);
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    ent_st_e           st   [N_ENT];
    logic [HASH_W-1:0] hv   [N_ENT];
    logic              gone [N_ENT];
    logic [IW-1:0]     ins_idx;
    logic [N_ENT-1:0]  req_any;

    // Lookups, free-entry search and export of dying hashes.
    always_comb begin
        has_free  = 1'b0;
        ins_idx   = '0;
        req_live  = 1'b0;
        ins_taken = 1'b0;
        rc_live   = 1'b0;
        rc_dying  = 1'b0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (st[e] == ENT_FREE) begin
                has_free = 1'b1;
                ins_idx  = IW'(e);
            end
        end
        for (int e = 0; e < N_ENT; e++) begin
            req_any[e]    = (st[e] != ENT_FREE) && (hv[e] == req_hash);
            req_live      = req_live  | ((st[e] == ENT_LIVE)  && (hv[e] == req_hash));
            ins_taken     = ins_taken | ((st[e] != ENT_FREE)  && (hv[e] == ins_hash));
            rc_live       = rc_live   | ((st[e] == ENT_LIVE)  && (hv[e] == rc_hash));
            rc_dying      = rc_dying  | ((st[e] == ENT_DYING) && (hv[e] == rc_hash));
            dying_vec[e]  = (st[e] == ENT_DYING);
            dying_hash[e] = hv[e];
        end
    end

    // Entry lifecycle: insert, retire on remove, mark dropped, free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) begin
                st[e]   <= ENT_FREE;
                hv[e]   <= '0;
                gone[e] <= 1'b0;
            end
        end else begin
            for (int e = 0; e < N_ENT; e++) begin
                if (ins_en && (ins_idx == IW'(e))) begin
                    st[e]   <= ENT_LIVE;
                    hv[e]   <= ins_hash;
                    gone[e] <= 1'b0;
                end else if (rem_en && (st[e] == ENT_LIVE) && (hv[e] == rem_hash)) begin
                    st[e]   <= ENT_DYING;
                    gone[e] <= 1'b0;
                end else if (st[e] == ENT_DYING) begin
                    if (gone[e] && !ent_pend[e]) begin
                        st[e] <= ENT_FREE;
                    end else if (gone_en && (hv[e] == rc_hash)) begin
                        gone[e] <= 1'b1;
                    end
                end
            end
        end
    end

    AST_HASH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_any)); // R1
    AST_INS_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) ins_en |-> (has_free && !ins_taken)); // R2
endmodule

// File: rtl/lcm_park_buf.sv
// Module: lcm_park_buf
// Pending-request buffer. Each slot holds valid, hash, key and client.
// Parks into the lowest free slot, offers the lowest slot matching the
// record being served, offers the lowest slot whose hash belongs to a dying
// table entry for flushing, and reports per table entry whether any slot
// still carries its hash.
// Assumes: srv_take and fl_take never name the same slot (hashes differ).
module lcm_park_buf #(
    parameter int N_SLOT = 8,
    parameter int N_ENT  = 8,
    parameter int HASH_W = 16,
    parameter int KEY_W  = 64,
    parameter int CID_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          park_en,
    input  logic [HASH_W-1:0]             park_hash,
    input  logic [KEY_W-1:0]              park_key,
    input  logic [CID_W-1:0]              park_client,
    output logic                          has_free,
    input  logic [HASH_W-1:0]             srv_hash,
    output logic                          srv_found,
    output logic [CID_W-1:0]              srv_client,
    input  logic                          srv_take,
    input  logic [N_ENT-1:0]              dying_vec,
    input  logic [N_ENT-1:0][HASH_W-1:0]  dying_hash,
    output logic                          fl_found,
    output logic [HASH_W-1:0]             fl_hash,
    output logic [KEY_W-1:0]              fl_key,
    output logic [CID_W-1:0]              fl_client,
    input  logic                          fl_take,
    output logic [N_ENT-1:0]              ent_pend
);
    localparam int SW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    logic              vld [N_SLOT];
    logic [HASH_W-1:0] sh  [N_SLOT];
    logic [KEY_W-1:0]  sk  [N_SLOT];
    logic [CID_W-1:0]  sc  [N_SLOT];
    logic [SW-1:0]     free_idx, srv_idx, fl_idx;
    logic [N_SLOT-1:0] dmatch;

    // Lowest-index searches for free, serve and flush candidates.
    always_comb begin
        has_free  = 1'b0;
        srv_found = 1'b0;
        fl_found  = 1'b0;
        free_idx  = '0;
        srv_idx   = '0;
        fl_idx    = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            dmatch[s] = 1'b0;
            for (int e = 0; e < N_ENT; e++) begin
                dmatch[s] = dmatch[s] | (vld[s] && dying_vec[e] && (dying_hash[e] == sh[s]));
            end
        end
        for (int s = N_SLOT - 1; s >= 0; s--) begin
            if (!vld[s]) begin
                has_free = 1'b1;
                free_idx = SW'(s);
            end
            if (vld[s] && (sh[s] == srv_hash)) begin
                srv_found = 1'b1;
                srv_idx   = SW'(s);
            end
            if (dmatch[s]) begin
                fl_found = 1'b1;
                fl_idx   = SW'(s);
            end
        end
        srv_client = sc[srv_idx];
        fl_hash    = sh[fl_idx];
        fl_key     = sk[fl_idx];
        fl_client  = sc[fl_idx];
    end

    // Per table entry: does any parked request still carry its hash.
    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            ent_pend[e] = 1'b0;
            for (int s = 0; s < N_SLOT; s++) begin
                ent_pend[e] = ent_pend[e] | (vld[s] && (sh[s] == dying_hash[e]));
            end
        end
    end

    // Slot writes: park fills, serve and flush release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOT; s++) begin
                vld[s] <= 1'b0;
                sh[s]  <= '0;
                sk[s]  <= '0;
                sc[s]  <= '0;
            end
        end else begin
            for (int s = 0; s < N_SLOT; s++) begin
                if (park_en && (free_idx == SW'(s))) begin
                    vld[s] <= 1'b1;
                    sh[s]  <= park_hash;
                    sk[s]  <= park_key;
                    sc[s]  <= park_client;
                end else if ((srv_take && (srv_idx == SW'(s))) ||
                             (fl_take && (fl_idx == SW'(s)))) begin
                    vld[s] <= 1'b0;
                end
            end
        end
    end

    AST_PARK_ROOM: assert property (@(posedge clk) disable iff (!rst_n) park_en |-> has_free); // R8
    AST_SERVE_FOUND: assert property (@(posedge clk) disable iff (!rst_n) srv_take |-> srv_found); // R6
    AST_TAKE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) (srv_take && fl_take) |-> (srv_idx != fl_idx)); // R9
endmodule

// File: rtl/lcm_orbit_engine.sv
// Module: lcm_orbit_engine
// Takes one record at a time (a newly inserted one, or one returning on the
// loopback). While the record's hash is live, it releases one matching parked
// request per cycle, then re-emits the record. If the hash is dying, it drops
// the record and tells the table.
// Assumes: ins_go and rin_go are only raised while idle is high.
module lcm_orbit_engine
    import lcm_pkg::*;
#(
    parameter int KEY_W  = 64,
    parameter int VAL_W  = 32,
    parameter int HASH_W = 16,
    parameter int CID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_go,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [VAL_W-1:0]  ins_val,
    input  logic [HASH_W-1:0] ins_hash,
    input  logic              rin_go,
    input  logic [KEY_W-1:0]  rin_key,
    input  logic [VAL_W-1:0]  rin_val,
    input  logic [HASH_W-1:0] rin_hash,
    output logic              idle,
    output logic [HASH_W-1:0] rec_hash,
    input  logic              rc_live,
    input  logic              rc_dying,
    input  logic              srv_found,
    input  logic [CID_W-1:0]  srv_client,
    output logic              srv_take,
    output logic              gone_en,
    output logic              rsp_valid,
    output logic [CID_W-1:0]  rsp_client,
    output logic [KEY_W-1:0]  rsp_key,
    output logic [VAL_W-1:0]  rsp_val,
    output logic              rout_valid,
    output logic [KEY_W-1:0]  rout_key,
    output logic [VAL_W-1:0]  rout_val
);
    eng_st_e          st;
    logic [KEY_W-1:0] rec_key;
    logic [VAL_W-1:0] rec_val;

    assign idle     = (st == ENG_IDLE);
    assign srv_take = (st == ENG_SERVE) && rc_live && srv_found;
    assign gone_en  = (st == ENG_SERVE) && !rc_live && rc_dying;

    // Record capture, per-cycle release and re-emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ENG_IDLE;
            rec_key    <= '0;
            rec_val    <= '0;
            rec_hash   <= '0;
            rsp_valid  <= 1'b0;
            rsp_client <= '0;
            rsp_key    <= '0;
            rsp_val    <= '0;
            rout_valid <= 1'b0;
            rout_key   <= '0;
            rout_val   <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            rout_valid <= 1'b0;
            case (st)
                ENG_IDLE: begin
                    if (ins_go) begin
                        rec_key  <= ins_key;
                        rec_val  <= ins_val;
                        rec_hash <= ins_hash;
                        st       <= ENG_SERVE;
                    end else if (rin_go) begin
                        rec_key  <= rin_key;
                        rec_val  <= rin_val;
                        rec_hash <= rin_hash;
                        st       <= ENG_SERVE;
                    end
                end
                ENG_SERVE: begin
                    if (rc_live && srv_found) begin
                        rsp_valid  <= 1'b1;
                        rsp_client <= srv_client;
                        rsp_key    <= rec_key;
                        rsp_val    <= rec_val;
                    end else begin
                        rout_valid <= rc_live;
                        rout_key   <= rec_key;
                        rout_val   <= rec_val;
                        st         <= ENG_IDLE;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    AST_RSP_ROUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_valid && rout_valid)); // R7
    AST_RSP_FROM_SERVE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(st == ENG_SERVE)); // R5
    AST_ROUT_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_n) rout_valid |-> (st == ENG_IDLE)); // R7
endmodule

// File: rtl/loop_cache_matcher.sv
// Module: loop_cache_matcher (top)
// Load-balancing cache core that stores only key hashes and pending
// requests. Hits park, misses and overflow go to a backend chosen as
// hash modulo N_SRV, circulating records release parked requests, and
// removed items are flushed to the backend and their records dropped.
// Assumes: KEY_W is a multiple of HASH_W; N_SRV >= 2; inputs are one-cycle
// pulses qualified by their valid bits.
module loop_cache_matcher #(
    parameter int KEY_W  = 64,
    parameter int HASH_W = 16,
    parameter int VAL_W  = 32,
    parameter int CID_W  = 8,
    parameter int N_ENT  = 8,
    parameter int N_SLOT = 8,
    parameter int N_SRV  = 3,
    localparam int SRV_W = $clog2(N_SRV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [CID_W-1:0]  req_client,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [VAL_W-1:0]  ins_value,
    input  logic              rem_valid,
    input  logic [KEY_W-1:0]  rem_key,
    input  logic              rin_valid,
    output logic              rin_ready,
    input  logic [KEY_W-1:0]  rin_key,
    input  logic [VAL_W-1:0]  rin_value,
    output logic              rout_valid,
    output logic [KEY_W-1:0]  rout_key,
    output logic [VAL_W-1:0]  rout_value,
    output logic              rsp_valid,
    output logic [CID_W-1:0]  rsp_client,
    output logic [KEY_W-1:0]  rsp_key,
    output logic [VAL_W-1:0]  rsp_value,
    output logic              fwd_valid,
    output logic [SRV_W-1:0]  fwd_server,
    output logic [KEY_W-1:0]  fwd_key,
    output logic [CID_W-1:0]  fwd_client
);
    localparam int N_HPORT = 4;

    logic [N_HPORT-1:0][KEY_W-1:0]  hkey;
    logic [N_HPORT-1:0][HASH_W-1:0] hval;
    logic [HASH_W-1:0] h_req, h_ins, h_rem, h_rin, rec_hash;
    logic req_live, ins_taken, tbl_free, rc_live, rc_dying, gone_en;
    logic [N_ENT-1:0] dying_vec, ent_pend;
    logic [N_ENT-1:0][HASH_W-1:0] dying_hash;
    logic buf_free, srv_found, srv_take, fl_found, fl_take;
    logic [CID_W-1:0] srv_client, fl_client;
    logic [HASH_W-1:0] fl_hash, sel_hash;
    logic [KEY_W-1:0] fl_key;
    logic eng_idle, ins_go, rin_go, park_en, fwd_req;

    assign hkey = {rin_key, rem_key, ins_key, req_key};

    // One hash unit per key source.
    for (genvar g = 0; g < N_HPORT; g++) begin : g_hash
        lcm_hash #(.KEY_W(KEY_W), .HASH_W(HASH_W)) u_hash (
            .key  (hkey[g]),
            .hash (hval[g])
        );
    end

    assign h_req = hval[0];
    assign h_ins = hval[1];
    assign h_rem = hval[2];
    assign h_rin = hval[3];

    // Admission and port-sharing decisions.
    always_comb begin
        ins_ready = eng_idle;
        rin_ready = eng_idle && !ins_valid;
        ins_go    = ins_valid && eng_idle && !ins_taken && tbl_free;
        rin_go    = rin_valid && rin_ready;
        park_en   = req_valid && req_live && buf_free;
        fwd_req   = req_valid && !park_en;
        fl_take   = fl_found && !fwd_req;
        sel_hash  = fwd_req ? h_req : fl_hash;
    end

    lcm_key_table #(.N_ENT(N_ENT), .HASH_W(HASH_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_hash   (h_req),
        .req_live   (req_live),
        .ins_en     (ins_go),
        .ins_hash   (h_ins),
        .ins_taken  (ins_taken),
        .has_free   (tbl_free),
        .rem_en     (rem_valid),
        .rem_hash   (h_rem),
        .rc_hash    (rec_hash),
        .rc_live    (rc_live),
        .rc_dying   (rc_dying),
        .gone_en    (gone_en),
        .dying_vec  (dying_vec),
        .dying_hash (dying_hash),
        .ent_pend   (ent_pend)
    );

    lcm_park_buf #(
        .N_SLOT(N_SLOT), .N_ENT(N_ENT), .HASH_W(HASH_W), .KEY_W(KEY_W), .CID_W(CID_W)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .park_en     (park_en),
        .park_hash   (h_req),
        .park_key    (req_key),
        .park_client (req_client),
        .has_free    (buf_free),
        .srv_hash    (rec_hash),
        .srv_found   (srv_found),
        .srv_client  (srv_client),
        .srv_take    (srv_take),
        .dying_vec   (dying_vec),
        .dying_hash  (dying_hash),
        .fl_found    (fl_found),
        .fl_hash     (fl_hash),
        .fl_key      (fl_key),
        .fl_client   (fl_client),
        .fl_take     (fl_take),
        .ent_pend    (ent_pend)
    );

    lcm_orbit_engine #(
        .KEY_W(KEY_W), .VAL_W(VAL_W), .HASH_W(HASH_W), .CID_W(CID_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_go     (ins_go),
        .ins_key    (ins_key),
        .ins_val    (ins_value),
        .ins_hash   (h_ins),
        .rin_go     (rin_go),
        .rin_key    (rin_key),
        .rin_val    (rin_value),
        .rin_hash   (h_rin),
        .idle       (eng_idle),
        .rec_hash   (rec_hash),
        .rc_live    (rc_live),
        .rc_dying   (rc_dying),
        .srv_found  (srv_found),
        .srv_client (srv_client),
        .srv_take   (srv_take),
        .gone_en    (gone_en),
        .rsp_valid  (rsp_valid),
        .rsp_client (rsp_client),
        .rsp_key    (rsp_key),
        .rsp_val    (rsp_value),
        .rout_valid (rout_valid),
        .rout_key   (rout_key),
        .rout_val   (rout_value)
    );

    // Registered backend port: new requests first, then flushes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid  <= 1'b0;
            fwd_server <= '0;
            fwd_key    <= '0;
            fwd_client <= '0;
        end else begin
            fwd_valid  <= fwd_req || fl_found;
            fwd_server <= SRV_W'(sel_hash % HASH_W'(N_SRV));
            fwd_key    <= fwd_req ? req_key : fl_key;
            fwd_client <= fwd_req ? req_client : fl_client;
        end
    end

    AST_MISS_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_live) |=> (fwd_valid && (fwd_client == $past(req_client)))); // R4
    AST_HIT_NO_REQ_FWD: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_live && buf_free && !fl_found) |=> !fwd_valid); // R3
endmodule

// File: tb/sim_loop_cache_matcher.sv
module sim_loop_cache_matcher;
    localparam int KEY_W = 64, VAL_W = 32, CID_W = 8, N_SRV = 3, SRV_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid, ins_valid, rem_valid, rin_valid;
    logic [KEY_W-1:0] req_key, ins_key, rem_key, rin_key;
    logic [CID_W-1:0] req_client;
    logic [VAL_W-1:0] ins_value, rin_value;
    logic ins_ready, rin_ready, rout_valid, rsp_valid, fwd_valid;
    logic [KEY_W-1:0] rout_key, rsp_key, fwd_key;
    logic [VAL_W-1:0] rout_value, rsp_value;
    logic [CID_W-1:0] rsp_client, fwd_client;
    logic [SRV_W-1:0] fwd_server;

    loop_cache_matcher u0 (.*);

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;
    int nr = 0, nf = 0, no = 0;
    logic [CID_W-1:0] r_cl [64];
    logic [KEY_W-1:0] r_key [64];
    logic [VAL_W-1:0] r_val [64];
    int               r_cyc [64];
    logic [CID_W-1:0] f_cl [64];
    logic [KEY_W-1:0] f_key [64];
    logic [SRV_W-1:0] f_srv [64];
    logic [KEY_W-1:0] o_key [64];
    logic [VAL_W-1:0] o_val [64];
    int               o_cyc [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rsp_valid && nr < 64) begin
            r_cl[nr] = rsp_client; r_key[nr] = rsp_key; r_val[nr] = rsp_value; r_cyc[nr] = cyc; nr++;
        end
        if (fwd_valid && nf < 64) begin
            f_cl[nf] = fwd_client; f_key[nf] = fwd_key; f_srv[nf] = fwd_server; nf++;
        end
        if (rout_valid && no < 64) begin
            o_key[no] = rout_key; o_val[no] = rout_value; o_cyc[no] = cyc; no++;
        end
    end

    function automatic logic [15:0] hf(input logic [63:0] k);
        return k[15:0] ^ k[31:16] ^ k[47:32] ^ k[63:48];
    endfunction

    function automatic logic [SRV_W-1:0] sv(input logic [63:0] k);
        return SRV_W'(hf(k) % 16'(N_SRV));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask
    task automatic settle(input int n); repeat (n) tick(); endtask
    task automatic clr(); nr = 0; nf = 0; no = 0; endtask

    task automatic send_req(input logic [63:0] k, input logic [7:0] c);
        req_valid = 1'b1; req_key = k; req_client = c; tick(); req_valid = 1'b0;
    endtask

    task automatic do_insert(input logic [63:0] k, input logic [31:0] v, output int c0);
        while (!ins_ready) tick();
        ins_valid = 1'b1; ins_key = k; ins_value = v; c0 = cyc; tick(); ins_valid = 1'b0;
    endtask

    task automatic do_recirc(input logic [63:0] k, input logic [31:0] v);
        while (!rin_ready) tick();
        rin_valid = 1'b1; rin_key = k; rin_value = v; tick(); rin_valid = 1'b0;
    endtask

    localparam logic [63:0] KA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] KB = 64'h1111_2222_33CC_44BB;
    localparam logic [63:0] KM = 64'hDEAD_0000_BEEF_0001;
    localparam logic [63:0] KC = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] KD = 64'hFEDC_0000_0000_0001;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0;
        bit ok;
        logic [63:0] rk [4];
        logic [31:0] rv [4];
        logic [63:0] mk [4];
        logic [7:0]  eh [4][8];
        int          nh [4];
        logic [7:0]  em_cl [8];
        logic [SRV_W-1:0] em_srv [8];
        logic [7:0] cl;
        int nmiss, nhit;
        void'($urandom(32'd1234));
        req_valid = 0; ins_valid = 0; rem_valid = 0; rin_valid = 0;
        req_key = 0; ins_key = 0; rem_key = 0; rin_key = 0;
        req_client = 0; ins_value = 0; rin_value = 0;
        settle(3); rst_n = 1'b1; tick();

        // R11 reset state
        chk(!rsp_valid && !fwd_valid && !rout_valid, "R11 reset valids", {rsp_valid, fwd_valid, rout_valid}, 0);
        chk(ins_ready && rin_ready, "R11 reset readies", {ins_ready, rin_ready}, 2'b11);

        // R4 miss forward
        clr(); send_req(KM, 8'd7); settle(2);
        chk(nf == 1 && f_cl[0] == 8'd7 && f_key[0] == KM, "R4 miss forward", f_cl[0], 7);
        chk(f_srv[0] == sv(KM), "R4 server select", f_srv[0], sv(KM));

        // R2 insert emits record two edges later
        clr(); do_insert(KA, 32'hAAAA_0001, c0); settle(3);
        chk(no == 1 && o_key[0] == KA && o_val[0] == 32'hAAAA_0001, "R2 insert record", no, 1);
        chk(o_cyc[0] == c0 + 2, "R2 insert timing", o_cyc[0], c0 + 2);
        clr(); do_insert(KA, 32'hBAD0_0000, c0); settle(3);
        chk(no == 0, "R2 duplicate insert ignored", no, 0);

        // R3 parking, R1 collision key, R5/R6/R7 release
        clr();
        send_req(KA, 8'd1); send_req(KA, 8'd2); send_req(KA, 8'd3); send_req(KB, 8'd4);
        settle(2);
        chk(nf == 0 && nr == 0, "R3 hits parked", nf, 0);
        do_recirc(KA, 32'hAAAA_0001);
        chk(!rin_ready, "R11 busy while serving", rin_ready, 0);
        settle(8);
        chk(nr == 4, "R5 response count", nr, 4);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (r_cl[i] != 8'(i + 1) || r_val[i] != 32'hAAAA_0001 || r_key[i] != KA) ok = 1'b0;
            if (i > 0 && r_cyc[i] != r_cyc[i-1] + 1) ok = 1'b0;
        end
        chk(ok, "R6 order and pacing", r_cl[3], 4);
        chk(r_key[3] == KA, "R1 collision answered with cached key", r_key[3], KA);
        chk(no == 1 && o_cyc[0] == r_cyc[3] + 1 && o_key[0] == KA, "R7 re-emit after last", o_cyc[0], r_cyc[3] + 1);
        clr(); do_recirc(KA, 32'hAAAA_0001); settle(4);
        chk(nr == 0 && no == 1, "R5 slots freed after response", nr, 0);

        // R8 buffer full
        clr();
        for (int i = 0; i < 8; i++) send_req(KA, 8'(10 + i));
        send_req(KA, 8'd18); settle(2);
        chk(nf == 1 && f_cl[0] == 8'd18 && f_srv[0] == sv(KA), "R8 overflow forwarded", f_cl[0], 18);
        clr(); do_recirc(KA, 32'hAAAA_0001); settle(12);
        chk(nr == 8 && r_cl[7] == 8'd17, "R8 full buffer drained", nr, 8);

        // R10 park during own serving pass; R11 insert priority
        clr();
        while (!ins_ready) tick();
        ins_valid = 1'b1; ins_key = KC; ins_value = 32'hCCCC_0003; rin_valid = 1'b1; rin_key = KA; rin_value = 32'hAAAA_0001;
        #1 chk(!rin_ready, "R11 insert has priority", rin_ready, 0);
        tick(); ins_valid = 1'b0; rin_valid = 1'b0; settle(3);
        clr(); send_req(KC, 8'd30); settle(1);
        while (!rin_ready) tick();
        rin_valid = 1'b1; rin_key = KC; rin_value = 32'hCCCC_0003; tick(); rin_valid = 1'b0;
        send_req(KC, 8'd31); settle(5);
        chk(nr == 2 && r_cl[0] == 8'd30 && r_cl[1] == 8'd31, "R10 late park served same pass", nr, 2);
        chk(no == 1 && o_cyc[0] == r_cyc[1] + 1, "R10 record after late response", no, 1);

        // R9 remove / R12 forward priority
        clr(); do_insert(KD, 32'hDDDD_0004, c0); settle(3);
        send_req(KD, 8'd40); send_req(KD, 8'd41); send_req(KD, 8'd42); settle(2);
        clr();
        rem_valid = 1'b1; rem_key = KD; tick(); rem_valid = 1'b0;
        send_req(KM, 8'd50); settle(6);
        chk(nf == 4 && f_cl[0] == 8'd50 && f_srv[0] == sv(KM), "R12 new request before flush", f_cl[0], 50);
        chk(f_cl[1] == 8'd40 && f_cl[2] == 8'd41 && f_cl[3] == 8'd42 && f_key[1] == KD && f_srv[3] == sv(KD),
            "R9 flush order", {f_cl[1], f_cl[2], f_cl[3]}, 24'h28292A);
        clr(); send_req(KD, 8'd43); settle(2);
        chk(nf == 1 && f_cl[0] == 8'd43, "R9 removed hash misses", nf, 1);
        clr(); do_recirc(KD, 32'hDDDD_0004); settle(4);
        chk(nr == 0 && no == 0, "R9 record dropped", no, 0);
        clr(); do_insert(KD, 32'hDDDD_0005, c0); settle(3);
        chk(no == 1 && o_val[0] == 32'hDDDD_0005, "R9 entry reusable", no, 1);

        // random rounds
        for (int k = 0; k < 4; k++) begin
            bit clash;
            do begin
                rk[k] = {$urandom, $urandom};
                clash = (hf(rk[k]) == hf(KA)) || (hf(rk[k]) == hf(KC)) || (hf(rk[k]) == hf(KD));
                for (int j = 0; j < k; j++) if (hf(rk[j]) == hf(rk[k])) clash = 1'b1;
            end while (clash);
            rv[k] = $urandom;
            do_insert(rk[k], rv[k], c0); settle(3);
        end
        for (int k = 0; k < 4; k++) begin
            bit clash;
            do begin
                mk[k] = {$urandom, $urandom};
                clash = (hf(mk[k]) == hf(KA)) || (hf(mk[k]) == hf(KC)) || (hf(mk[k]) == hf(KD));
                for (int j = 0; j < 4; j++) if (hf(rk[j]) == hf(mk[k])) clash = 1'b1;
            end while (clash);
        end
        cl = 8'd100;
        for (int rd = 0; rd < 150; rd++) begin
            int nq;
            clr(); nmiss = 0; nhit = 0;
            for (int k = 0; k < 4; k++) nh[k] = 0;
            nq = 1 + int'($urandom % 7);
            for (int q = 0; q < nq; q++) begin
                int p;
                p = int'($urandom % 8);
                if (p < 4) begin
                    eh[p][nh[p]] = cl; nh[p]++; nhit++;
                    send_req(rk[p], cl);
                end else begin
                    em_cl[nmiss] = cl; em_srv[nmiss] = sv(mk[p-4]); nmiss++;
                    send_req(mk[p-4], cl);
                end
                cl++;
                if ($urandom % 3 == 0) tick();
            end
            settle(2);
            for (int k = 0; k < 4; k++) do_recirc(rk[k], rv[k]);
            settle(12);
            ok = (nr == nhit);
            begin
                int idx = 0;
                for (int k = 0; k < 4; k++)
                    for (int j = 0; j < nh[k]; j++) begin
                        if (idx < nr && (r_cl[idx] != eh[k][j] || r_val[idx] != rv[k] || r_key[idx] != rk[k])) ok = 1'b0;
                        idx++;
                    end
            end
            chk(ok, "R5 random response sequence", nr, nhit);
            ok = (nf == nmiss);
            for (int j = 0; j < nmiss && j < nf; j++)
                if (f_cl[j] != em_cl[j] || f_srv[j] != em_srv[j]) ok = 1'b0;
            chk(ok, "R4 random forwards", nf, nmiss);
            chk(no == 4, "R7 random re-emission", no, 4);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule